// File: doc/BRIEF.md
# Instruction cycle sequencer

This block is the multicycle control unit of a small accumulator machine. Each instruction goes through a fetch sub-cycle, an optional indirect sub-cycle, an execute sub-cycle and, when an enabled interrupt request is pending, an interrupt sub-cycle. All memory traffic passes through an address holding register (which drives the address lines) and a data buffer register (which drives the write data and captures the read data). It uses one single-port memory with read and write strobes and a ready handshake.

The instruction word is 16 bits: opcode in bits 15:12, indirect flag in bit 11 and an 11-bit address field in bits 10:0. The program counter and stack pointer are 11 bits. An accepted interrupt pushes the return address onto a downward-growing stack and jumps to a fixed handler address. A two-bit phase output shows which sub-cycle is active in every clock.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is low the PC is 0, the stack pointer is 0x7FF, interrupts are disabled, the phase is fetch (0) and both strobes are low. The first interrupt push goes to 0x7FE.
- R2: Fetch copies the PC to the memory address, then holds a read. On the ready cycle the word is captured and the PC steps by one, modulo 2^11. The word is then decoded.
- R3: Opcodes: 1 load, 2 add, 3 and, 4 store, 5 jump, 6 interrupt enable, 7 interrupt disable. Every other opcode finishes execute in one cycle and changes no state.
- R4: With bit 11 set, the indirect sub-cycle reads the address field's location. The low 11 bits of that word become the effective address that execute uses.
- R5: Load puts the operand into the accumulator. Add writes the sum modulo 2^16. And writes the bitwise AND. The operand comes from one read at the effective address.
- R6: Store writes the accumulator to the effective address. Read and write strobes are never high together.
- R7: Jump loads the PC with the effective address without a data access.
- R8: While a strobe is high and ready is low, the strobe, address, write data and all visible state hold. Nothing advances.
- R9: At the end of execute, the interrupt sub-cycle starts only if the request is high and the enable flag was set before that instruction's own enable or disable took effect. Otherwise fetch follows.
- R10: The interrupt sub-cycle decrements the stack pointer and clears the enable flag. It writes the PC to the new stack address, then loads the PC with the handler address (0x100) and returns to fetch.
- R11: Phase encoding is 0 fetch, 1 indirect, 2 execute, 3 interrupt. Execute is always followed by fetch or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 11 | Memory address (address holding register) |
| mem_wdata | output | 16 | Memory write data (data buffer register) |
| mem_rdata | input | 16 | Memory read data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_ready | input | 1 | Access completes on a clock where this is high |
| irq | input | 1 | Interrupt request, level sensitive |
| phase_o | output | 2 | Current sub-cycle |
| pc_o | output | 11 | Program counter |
| acc_o | output | 16 | Accumulator |
| ien_o | output | 1 | Interrupt enable flag |

## Verification
Assertions check on every cycle:
- strobe and address hold through a stall;
- strobe exclusivity;
- fetch reads at the PC;
- indirect only follows fetch;
- an interrupt entry had the request and the flag set;
- the flag is clear inside the interrupt sub-cycle;
- the handler address is loaded on exit;
- execute is followed by fetch or interrupt.

Only the bench's program shows the rest:
- the accumulator values produced by load, add with wrap and and;
- indirect addressing for both reads and stores;
- the one-instruction delay of interrupt enable;
- no second entry while a request stays high;
- the pushed return address in memory.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  localparam int OPW = 4;

  typedef enum logic [3:0] {
    ST_F0, ST_F1, ST_F2,   // fetch: address, read, decode
    ST_N0, ST_N1,          // indirect: read pointer, load address
    ST_E0, ST_E1,          // execute: first, second step
    ST_T0, ST_T1           // interrupt: prepare push, write
  } st_t;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_IND   = 2'd1,
    PH_EXEC  = 2'd2,
    PH_INT   = 2'd3
  } phase_t;

  localparam logic [OPW-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPW-1:0] OP_ADD   = 4'd2;
  localparam logic [OPW-1:0] OP_AND   = 4'd3;
  localparam logic [OPW-1:0] OP_STORE = 4'd4;
  localparam logic [OPW-1:0] OP_JMP   = 4'd5;
  localparam logic [OPW-1:0] OP_EI    = 4'd6;
  localparam logic [OPW-1:0] OP_DI    = 4'd7;

  function automatic phase_t phase_of(st_t s);
    case (s)
      ST_F0, ST_F1, ST_F2: return PH_FETCH;
      ST_N0, ST_N1:        return PH_IND;
      ST_E0, ST_E1:        return PH_EXEC;
      default:             return PH_INT;
    endcase
  endfunction

  function automatic logic op_reads(logic [OPW-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_AND);
  endfunction
endpackage

// File: rtl/seq_alu.sv
`timescale 1ns/1ps
module seq_alu
  import seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  opnd,
  output logic [DW-1:0]  y
);
  function automatic logic [DW-1:0] alu_fn(logic [OPW-1:0] o, logic [DW-1:0] a, logic [DW-1:0] b);
    case (o)
      OP_ADD:  return a + b;
      OP_AND:  return a & b;
      default: return b;
    endcase
  endfunction

  assign y = alu_fn(op, acc, opnd);
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mem_ready,
  input  logic           ind_bit,
  input  logic [OPW-1:0] op,
  input  logic           irq,
  input  logic           ien,
  output st_t            state,
  output logic           rd,
  output logic           wr,
  output logic           instr_done,
  output logic           irq_take
);
  st_t  st_q, st_d;
  logic rd_op, st_op;

  always_comb begin
    rd_op      = op_reads(op);
    st_op      = (op == OP_STORE);
    instr_done = ((st_q == ST_E0) && !rd_op && !st_op) ||
                 ((st_q == ST_E1) && (!st_op || mem_ready));
    irq_take   = instr_done && irq && ien;
    rd         = (st_q == ST_F1) || (st_q == ST_N0) || ((st_q == ST_E0) && rd_op);
    wr         = ((st_q == ST_E1) && st_op) || (st_q == ST_T1);

    st_d = st_q;
    case (st_q)
      ST_F0: st_d = ST_F1;
      ST_F1: if (mem_ready) st_d = ST_F2;
      ST_F2: st_d = ind_bit ? ST_N0 : ST_E0;
      ST_N0: if (mem_ready) st_d = ST_N1;
      ST_N1: st_d = ST_E0;
      ST_E0: if ((rd_op && mem_ready) || st_op) st_d = ST_E1;
      ST_T0: st_d = ST_T1;
      ST_T1: if (mem_ready) st_d = ST_F0;
      default: ;
    endcase
    if (instr_done) st_d = irq_take ? ST_T0 : ST_F0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_F0;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/instr_cycle_seq.sv
`timescale 1ns/1ps
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int AW      = 11,
  parameter int DW      = 16,
  parameter int HANDLER = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          mem_ready,
  input  logic          irq,
  output logic [1:0]    phase_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic          ien_o
);
  localparam int            IND_BIT   = AW;
  localparam logic [AW-1:0] SP_TOP    = '1;
  localparam logic [AW-1:0] HANDLER_A = AW'(HANDLER);

  logic [AW-1:0]  pc, mar, sp;
  logic [DW-1:0]  mbr, acc, alu_y;
  logic [OPW-1:0] ir_op;
  logic           ien;

  // control events, brought out by name for the checker
  st_t  state;
  logic instr_done, irq_take;

  seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .ind_bit(mbr[IND_BIT]),
    .op(ir_op), .irq(irq), .ien(ien), .state(state), .rd(mem_rd), .wr(mem_wr),
    .instr_done(instr_done), .irq_take(irq_take)
  );

  seq_alu #(.DW(DW)) u_alu (.op(ir_op), .acc(acc), .opnd(mbr), .y(alu_y));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      mar   <= '0;
      mbr   <= '0;
      ir_op <= '0;
      acc   <= '0;
      sp    <= SP_TOP;
      ien   <= 1'b0;
    end else begin
      case (state)
        ST_F0: mar <= pc;
        ST_F1: if (mem_ready) begin
          mbr <= mem_rdata;
          pc  <= pc + 1'b1;
        end
        ST_F2: begin
          ir_op <= mbr[DW-1 -: OPW];
          mar   <= mbr[AW-1:0];
        end
        ST_N0: if (mem_ready) mbr <= mem_rdata;
        ST_N1: mar <= mbr[AW-1:0];
        ST_E0: case (ir_op)
          OP_LOAD, OP_ADD, OP_AND: if (mem_ready) mbr <= mem_rdata;
          OP_STORE: mbr <= acc;
          OP_JMP:   pc  <= mar;
          OP_EI:    ien <= 1'b1;
          OP_DI:    ien <= 1'b0;
          default: ;
        endcase
        ST_E1: if (op_reads(ir_op)) acc <= alu_y;
        ST_T0: begin
          sp  <= sp - 1'b1;
          mar <= sp - 1'b1;
          mbr <= {{(DW-AW){1'b0}}, pc};
          ien <= 1'b0;
        end
        ST_T1: if (mem_ready) pc <= HANDLER_A;
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign phase_o   = phase_of(state);
  assign pc_o      = pc;
  assign acc_o     = acc;
  assign ien_o     = ien;
endmodule

// File: rtl/seq_chk.sv
`timescale 1ns/1ps
module seq_chk
  import seq_pkg::*;
#(
  parameter int AW      = 11,
  parameter int DW      = 16,
  parameter int HANDLER = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [AW-1:0] pc,
  input logic          ien,
  input logic          irq,
  input logic          instr_done
);
  // R8
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
  // R8
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH && mem_rd) |-> (mem_addr == pc));
  // R4
  ind_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IND && $past(phase) != PH_IND) |-> ($past(phase) == PH_FETCH));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INT && $past(phase) == PH_EXEC) |-> $past(ien && irq));
  // R10
  ien_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INT && $past(phase) == PH_INT) |-> !ien);
  // R10
  handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH && $past(phase) == PH_INT) |-> (pc == AW'(HANDLER)));
  // R11
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (phase == PH_FETCH || phase == PH_INT));
endmodule

bind instr_cycle_seq seq_chk #(.AW(AW), .DW(DW), .HANDLER(HANDLER)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase_o), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc(pc_o),
  .ien(ien_o), .irq(irq), .instr_done(instr_done)
);

// File: tb/tb_instr_cycle_seq.sv
`timescale 1ns/1ps
module tb_instr_cycle_seq;
  localparam int AW = 11, DW = 16, HANDLER = 256;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] mem_addr, pc_o;
  logic [DW-1:0] mem_wdata, mem_rdata, acc_o;
  logic mem_rd, mem_wr, ien_o;
  logic rdy = 1'b0, irq_i = 1'b0;
  logic [1:0] phase_o;

  always #2.5 clk = ~clk;

  instr_cycle_seq #(.AW(AW), .DW(DW), .HANDLER(HANDLER)) dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(rdy),
    .irq(irq_i), .phase_o(phase_o), .pc_o(pc_o), .acc_o(acc_o), .ien_o(ien_o)
  );

  logic [DW-1:0] mem   [MEMSZ];
  logic [DW-1:0] m_mem [MEMSZ];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (rst_n && mem_wr && rdy) mem[mem_addr] <= mem_wdata;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model: integer step number, plain variables
  int m_st;
  int m_pc, m_mar, m_sp, m_mbr, m_acc, m_op;
  bit m_ien;

  function automatic bit m_reads(int op);
    return op >= 1 && op <= 3;
  endfunction

  task automatic m_end_instr(input bit ien_before);
    m_st = (irq_i && ien_before) ? 7 : 0;
  endtask

  task automatic advance();
    bit ie;
    ie = m_ien;
    case (m_st)
      0: begin m_mar = m_pc; m_st = 1; end
      1: if (rdy) begin m_mbr = m_mem[m_mar]; m_pc = (m_pc + 1) % MEMSZ; m_st = 2; end
      2: begin
        m_op = m_mbr >> 12; m_mar = m_mbr % MEMSZ;
        m_st = ((m_mbr >> 11) & 1) ? 3 : 5;
      end
      3: if (rdy) begin m_mbr = m_mem[m_mar]; m_st = 4; end
      4: begin m_mar = m_mbr % MEMSZ; m_st = 5; end
      5: begin
        if (m_reads(m_op)) begin
          if (rdy) begin m_mbr = m_mem[m_mar]; m_st = 6; end
        end else if (m_op == 4) begin
          m_mbr = m_acc; m_st = 6;
        end else begin
          if (m_op == 5) m_pc = m_mar;
          if (m_op == 6) m_ien = 1;
          if (m_op == 7) m_ien = 0;
          m_end_instr(ie);
        end
      end
      6: begin
        if (m_op == 1) begin m_acc = m_mbr; m_end_instr(ie); end
        else if (m_op == 2) begin m_acc = (m_acc + m_mbr) % 65536; m_end_instr(ie); end
        else if (m_op == 3) begin m_acc = m_acc & m_mbr; m_end_instr(ie); end
        else if (rdy) begin m_mem[m_mar] = 16'(m_mbr); m_end_instr(ie); end
      end
      7: begin m_sp = (m_sp + MEMSZ - 1) % MEMSZ; m_mar = m_sp; m_mbr = m_pc; m_ien = 0; m_st = 8; end
      8: if (rdy) begin m_mem[m_mar] = 16'(m_mbr); m_pc = HANDLER; m_st = 0; end
      default: ;
    endcase
  endtask

  task automatic compare();
    int ph; bit erd, ewr;
    ph  = (m_st <= 2) ? 0 : (m_st <= 4) ? 1 : (m_st <= 6) ? 2 : 3;
    erd = (m_st == 1) || (m_st == 3) || (m_st == 5 && m_reads(m_op));
    ewr = (m_st == 6 && m_op == 4) || (m_st == 8);
    chk("R11", "phase", 32'(phase_o), 32'(ph));
    chk("R8", "rd", 32'(mem_rd), 32'(erd));
    chk("R8", "wr", 32'(mem_wr), 32'(ewr));
    chk("R2", "pc", 32'(pc_o), 32'(m_pc));
    chk("R5", "acc", 32'(acc_o), 32'(m_acc));
    chk("R9", "ien", 32'(ien_o), 32'(m_ien));
    if (erd || ewr) chk("R4", "addr", 32'(mem_addr), 32'(m_mar));
    if (ewr) chk("R6", "wdata", 32'(mem_wdata), 32'(m_mbr));
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = '0;
    // main line
    mem[11'h000] = 16'h1040;  // load 0x40
    mem[11'h001] = 16'h2041;  // add 0x41
    mem[11'h002] = 16'h3842;  // and indirect via 0x42
    mem[11'h003] = 16'h4050;  // store 0x50
    mem[11'h004] = 16'h2044;  // add 0x44 (wraps)
    mem[11'h005] = 16'h5010;  // jump 0x10
    mem[11'h010] = 16'h9000;  // unused opcode
    mem[11'h011] = 16'h6000;  // enable interrupts
    mem[11'h012] = 16'h1845;  // load indirect via 0x45
    mem[11'h013] = 16'h7000;  // disable interrupts
    mem[11'h014] = 16'h4847;  // store indirect via 0x47
    mem[11'h015] = 16'h5015;  // jump to self
    // handler
    mem[11'h100] = 16'h1048;  // load 0x48
    mem[11'h101] = 16'h4052;  // store 0x52
    mem[11'h102] = 16'h5013;  // jump back
    // data
    mem[11'h040] = 16'h1234; mem[11'h041] = 16'h0F0F; mem[11'h042] = 16'h0043;
    mem[11'h043] = 16'hFF0F; mem[11'h044] = 16'hFFFF; mem[11'h045] = 16'h0046;
    mem[11'h046] = 16'hAAAA; mem[11'h047] = 16'h0051; mem[11'h048] = 16'h5555;
    for (int i = 0; i < MEMSZ; i++) m_mem[i] = mem[i];
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] lfsr;
    int irq_stage, int_entries, stalls;
    logic [1:0] prev_ph;
    logic [DW-1:0] acc_at_ei;
    bit saw_jump;
    lfsr = 5'h13; irq_stage = 0; int_entries = 0; stalls = 0; prev_ph = 2'd0;
    acc_at_ei = '0; saw_jump = 0;
    m_st = 0; m_pc = 0; m_mar = 0; m_mbr = 0; m_acc = 0; m_op = 0; m_sp = MEMSZ - 1; m_ien = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "phase", 32'(phase_o), 0);
    chk("R1", "pc", 32'(pc_o), 0);
    chk("R1", "ien", 32'(ien_o), 0);
    chk("R1", "strobes", 32'({mem_rd, mem_wr}), 0);
    rst_n = 1'b1;
    rdy = 1'b1;

    repeat (700) begin
      @(negedge clk);
      advance();
      compare();
      if (mem_rd && !rdy) stalls++;
      if (phase_o == 2'd3 && prev_ph != 2'd3) int_entries++;
      prev_ph = phase_o;
      if (pc_o == 11'h010) saw_jump = 1;
      case (irq_stage)
        0: if (pc_o == 11'h012) begin acc_at_ei = acc_o; irq_i = 1'b1; irq_stage = 1; end
        1: if (pc_o == 11'h103) begin irq_i = 1'b0; irq_stage = 2; end
        2: if (pc_o == 11'h016) begin irq_i = 1'b1; irq_stage = 3; end
        default: ;
      endcase
      lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      rdy  = lfsr[0] | lfsr[1];
    end

    chk("R3", "acc after unused opcode", 32'(acc_at_ei), 32'h2102);
    chk("R5", "and+add result stored", 32'(mem[11'h050]), 32'h2103);
    chk("R6", "handler store", 32'(mem[11'h052]), 32'h5555);
    chk("R4", "indirect store", 32'(mem[11'h051]), 32'h5555);
    chk("R10", "pushed return address", 32'(mem[11'h7FE]), 32'h0013);
    chk("R1", "stack untouched above push", 32'(mem[11'h7FF]), 32'h0000);
    chk("R9", "interrupt entries", 32'(int_entries), 1);
    chk("R9", "second request reached", 32'(irq_stage), 3);
    chk("R7", "jump target reached", 32'(saw_jump), 1);
    chk("R8", "read stalls seen", 32'(stalls > 0), 1);
    chk("R7", "final loop pc", 32'(pc_o == 11'h015 || pc_o == 11'h016), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule